// File: doc/BRIEF.md
# Instruction Fetch Address Translation Front End

This block sits between the instruction fetch stage and an instruction TLB and decides, for every fetch address, which translation path applies. A fetch request carries a 64-bit virtual address, a flag that requests untranslated (physical) addressing, and the current processor privilege mode. The block classifies the address combinationally. Only addresses that need a translation go to the TLB, as a lookup strobe plus a virtual page number. The TLB answers in the same cycle with a hit flag and a physical page number.

Several cases never reach the TLB. A fetch address with its lowest bit set marks privileged firmware code and is aligned and masked to the implemented physical width. A physical-mode request passes through unchanged. An address outside the implemented virtual range raises an access violation. A kernel-only direct-mapped window maps its low bits straight to physical bits. Every outcome appears one cycle after the request as exactly one of hit, miss or fault, together with a route code that names the path taken. Whenever a fault occurs, the block keeps the faulting PC and a formed fault address for the trap handler.

Top module: `ifetch_xlate_front`

## Requirements
- R1: A request whose address bit 0 is 1 is a firmware fetch. The response is a hit with route code 0, and its physical address is the virtual address with bits 1:0 cleared and every bit at or above bit 44 cleared.
- R2: A request with bit 0 clear and the physical-mode flag set is a hit with route code 1, and its physical address equals the full 64-bit virtual address.
- R3: Otherwise, an address whose bits 63:43 are not all copies of bit 42 raises a fault with route code 2, and the physical address is zero.
- R4: Otherwise, an address whose bits 47:41 equal 7'h7E lies in the direct-mapped window. In kernel mode (mode code 0), the response is a hit with route code 3 and physical address {23'b0, VA[40:0]}, and no TLB lookup is issued.
- R5: A direct-window access in any mode other than kernel (codes 1, 2, 3) raises a fault with route code 3 and a zero physical address.
- R6: On every fault, the captured tag becomes the faulting virtual address and the captured fault address becomes ptbr OR ({VA[42:13], 3'b000} zero-extended). Both keep their values through all cycles without a fault.
- R7: Every other request asserts tlb_lookup in the same cycle with tlb_vpn = VA[42:13]. When the TLB reports a hit, the response is a hit with route code 4 and physical address {20'b0, ppn[30:0], VA[12:0]}.
- R8: When a TLB lookup misses, the response is a miss with route code 4 and a zero physical address.
- R9: The response appears on the clock edge after the request, with exactly one of hit, miss and fault set. A cycle without a request produces a cycle with rsp_valid low and all result outputs zero.
- R10: The paths are chosen in strict priority: firmware marker, then physical mode, then the range check, then the direct window, then the TLB.
- R11: After reset, every output register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request present |
| req_va | input | 64 | Fetch virtual address |
| req_phys | input | 1 | Physical (untranslated) mode request |
| cur_mode | input | 2 | Privilege mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| ptbr | input | 64 | Page table base used to form the fault address |
| tlb_lookup | output | 1 | TLB lookup strobe |
| tlb_vpn | output | 30 | Virtual page number presented to the TLB |
| tlb_hit | input | 1 | TLB lookup result: hit |
| tlb_ppn | input | 31 | TLB physical page number |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 64 | Translated physical address |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | TLB miss |
| rsp_fault | output | 1 | Access violation |
| rsp_route | output | 3 | Path taken: 0 marker, 1 physical, 2 bad range, 3 direct window, 4 TLB |
| flt_tag | output | 64 | Captured faulting PC |
| flt_va_form | output | 64 | Captured formed fault address |

## Verification
The TLB strobe and page number are combinational, so the bench checks them one nanosecond after it drives a request, within the same cycle. Response fields and both fault capture registers are due on the next rising edge. The bench therefore compares them at the following falling edge, against a reference model that it updated when it applied the request. A request goes in on every falling edge, so each cycle's outputs are compared, including idle cycles that must read zero and must leave the capture registers unchanged.

// File: rtl/ifx_pkg.sv
package ifx_pkg;

    typedef enum logic [2:0] {
        RT_MARKER = 3'd0,
        RT_PHYS   = 3'd1,
        RT_BADVA  = 3'd2,
        RT_SUPER  = 3'd3,
        RT_TLB    = 3'd4
    } route_e;

    typedef enum logic [1:0] {
        MODE_KERNEL = 2'd0,
        MODE_EXEC   = 2'd1,
        MODE_SUPV   = 2'd2,
        MODE_USER   = 2'd3
    } cpu_mode_e;

    typedef struct packed {
        route_e route;
        logic   hit;
        logic   miss;
        logic   fault;
    } xlate_status_t;

    localparam xlate_status_t STATUS_IDLE = '{route: RT_MARKER, hit: 1'b0, miss: 1'b0, fault: 1'b0};

    // Low-width all-ones mask inside a wider word.
    function automatic logic [63:0] low_mask64(input int unsigned width);
        logic [63:0] m;
        for (int i = 0; i < 64; i++) begin
            m[i] = (i < width);
        end
        return m;
    endfunction

endpackage

// File: rtl/ifx_region_decode.sv
module ifx_region_decode
    import ifx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 44,
    parameter int IMPL_VA_W = 43,
    parameter int SP_LO     = 41,
    parameter logic [6:0] SP_KEY = 7'h7E
) (
    input  logic [VA_W-1:0] va,
    input  logic            phys,
    input  cpu_mode_e       mode,
    output route_e          route,
    output logic            acv,
    output logic            use_tlb,
    output logic [VA_W-1:0] bypass_pa
);
    localparam int SP_HI = SP_LO + 6;
    localparam int UPW   = VA_W - IMPL_VA_W + 1;
    localparam logic [VA_W-1:0] PA_MASK = VA_W'(low_mask64(PA_W));

    logic [UPW-1:0]  upper;
    logic            va_ok;
    logic            in_super;
    logic [VA_W-1:0] marker_pa;
    logic [VA_W-1:0] super_pa;

    assign upper     = va[VA_W-1:IMPL_VA_W-1];
    assign va_ok     = (&upper) | (~|upper);
    assign in_super  = (va[SP_HI:SP_LO] == SP_KEY);
    assign marker_pa = {va[VA_W-1:2], 2'b00} & PA_MASK;
    assign super_pa  = {{(VA_W-SP_LO){1'b0}}, va[SP_LO-1:0]};

    always_comb begin
        route     = RT_TLB;
        acv       = 1'b0;
        use_tlb   = 1'b0;
        bypass_pa = '0;
        if (va[0]) begin
            route     = RT_MARKER;
            bypass_pa = marker_pa;
        end else if (phys) begin
            route     = RT_PHYS;
            bypass_pa = va;
        end else if (!va_ok) begin
            route = RT_BADVA;
            acv   = 1'b1;
        end else if (in_super) begin
            route = RT_SUPER;
            if (mode == MODE_KERNEL) begin
                bypass_pa = super_pa;
            end else begin
                acv = 1'b1;
            end
        end else begin
            use_tlb = 1'b1;
        end
    end

    always_comb begin
        if (use_tlb) begin
            assert (!acv && bypass_pa == '0) else $error("AST_TLB_PATH_CLEAN"); // R7
        end
    end

endmodule

// File: rtl/ifx_tlb_merge.sv
module ifx_tlb_merge #(
    parameter int VA_W    = 64,
    parameter int PA_W    = 44,
    parameter int PG_BITS = 13
) (
    input  logic                    hit,
    input  logic [PA_W-PG_BITS-1:0] ppn,
    input  logic [PG_BITS-1:0]      offset,
    output logic [VA_W-1:0]         pa
);
    always_comb begin
        if (hit) begin
            pa = {{(VA_W-PA_W){1'b0}}, ppn, offset};
        end else begin
            pa = '0;
        end
    end
endmodule

// File: rtl/ifx_fault_capture.sv
module ifx_fault_capture #(
    parameter int VA_W      = 64,
    parameter int PG_BITS   = 13,
    parameter int IMPL_VA_W = 43
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fault_evt,
    input  logic [VA_W-1:0] va,
    input  logic [VA_W-1:0] ptbr,
    output logic [VA_W-1:0] tag,
    output logic [VA_W-1:0] form
);
    localparam int VPN_W = IMPL_VA_W - PG_BITS;

    logic [VA_W-1:0] vpn_shifted;
    assign vpn_shifted = {{(VA_W-VPN_W-3){1'b0}}, va[IMPL_VA_W-1:PG_BITS], 3'b000};

    always_ff @(posedge clk) begin
        if (rst) begin
            tag  <= '0;
            form <= '0;
        end else if (fault_evt) begin
            tag  <= va;
            form <= ptbr | vpn_shifted;
        end
    end

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fault_evt |=> $stable(tag) && $stable(form)); // R6
    AST_TAG_LOAD: assert property (@(posedge clk) disable iff (rst)
        fault_evt |=> tag == $past(va)); // R6

endmodule

// File: rtl/ifetch_xlate_front.sv
module ifetch_xlate_front
    import ifx_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 44,
    parameter int PG_BITS   = 13,
    parameter int IMPL_VA_W = 43,
    parameter int SP_LO     = 41,
    parameter logic [6:0] SP_KEY = 7'h7E,
    localparam int VPN_W    = IMPL_VA_W - PG_BITS,
    localparam int PPN_W    = PA_W - PG_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_phys,
    input  logic [1:0]       cur_mode,
    input  logic [VA_W-1:0]  ptbr,
    output logic             tlb_lookup,
    output logic [VPN_W-1:0] tlb_vpn,
    input  logic             tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    output logic             rsp_valid,
    output logic [VA_W-1:0]  rsp_pa,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [2:0]       rsp_route,
    output logic [VA_W-1:0]  flt_tag,
    output logic [VA_W-1:0]  flt_va_form
);
    route_e          dec_route;
    logic            dec_acv;
    logic            dec_use_tlb;
    logic [VA_W-1:0] dec_bypass_pa;
    logic [VA_W-1:0] tlb_pa;
    xlate_status_t   nxt_status;
    logic [VA_W-1:0] nxt_pa;
    xlate_status_t   status_q;
    logic [VA_W-1:0] pa_q;
    logic            valid_q;
    logic            fault_evt;

    ifx_region_decode #(
        .VA_W(VA_W), .PA_W(PA_W), .IMPL_VA_W(IMPL_VA_W),
        .SP_LO(SP_LO), .SP_KEY(SP_KEY)
    ) u_decode (
        .va(req_va),
        .phys(req_phys),
        .mode(cpu_mode_e'(cur_mode)),
        .route(dec_route),
        .acv(dec_acv),
        .use_tlb(dec_use_tlb),
        .bypass_pa(dec_bypass_pa)
    );

    ifx_tlb_merge #(
        .VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS)
    ) u_merge (
        .hit(tlb_hit),
        .ppn(tlb_ppn),
        .offset(req_va[PG_BITS-1:0]),
        .pa(tlb_pa)
    );

    assign tlb_lookup = req_valid & dec_use_tlb;
    assign tlb_vpn    = req_va[IMPL_VA_W-1:PG_BITS];
    assign fault_evt  = req_valid & dec_acv;

    always_comb begin
        nxt_status.route = dec_route;
        nxt_status.fault = dec_acv;
        nxt_status.miss  = dec_use_tlb & ~tlb_hit;
        nxt_status.hit   = ~dec_acv & ~(dec_use_tlb & ~tlb_hit);
        nxt_pa           = dec_use_tlb ? tlb_pa : dec_bypass_pa;
    end

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            valid_q  <= 1'b0;
            status_q <= STATUS_IDLE;
            pa_q     <= '0;
        end else begin
            valid_q  <= 1'b1;
            status_q <= nxt_status;
            pa_q     <= nxt_pa;
        end
    end

    ifx_fault_capture #(
        .VA_W(VA_W), .PG_BITS(PG_BITS), .IMPL_VA_W(IMPL_VA_W)
    ) u_capture (
        .clk(clk),
        .rst(rst),
        .fault_evt(fault_evt),
        .va(req_va),
        .ptbr(ptbr),
        .tag(flt_tag),
        .form(flt_va_form)
    );

    assign rsp_valid = valid_q;
    assign rsp_pa    = pa_q;
    assign rsp_hit   = status_q.hit;
    assign rsp_miss  = status_q.miss;
    assign rsp_fault = status_q.fault;
    assign rsp_route = status_q.route;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault && rsp_pa == '0); // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault})); // R9
    AST_MISS_NO_PA: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> rsp_pa == '0 && rsp_route == 3'(RT_TLB)); // R8
    AST_MARKER_ALIGN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_route == 3'(RT_MARKER) |-> rsp_pa[1:0] == 2'b00 && rsp_pa[VA_W-1:PA_W] == '0); // R1
    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_pa == '0); // R3
    AST_LOOKUP_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        tlb_lookup |-> req_valid && !req_va[0] && !req_phys); // R10
    AST_FAULT_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> flt_tag == $past(req_va)); // R6

endmodule

// File: tb/ifetch_xlate_front_bench.sv
module ifetch_xlate_front_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic        req_phys = 1'b0;
    logic [1:0]  cur_mode = 2'd0;
    logic [63:0] ptbr = 64'h0000_0002_4000_0000;
    logic        tlb_lookup;
    logic [29:0] tlb_vpn;
    logic        tlb_hit = 1'b0;
    logic [30:0] tlb_ppn = '0;
    logic        rsp_valid;
    logic [63:0] rsp_pa;
    logic        rsp_hit, rsp_miss, rsp_fault;
    logic [2:0]  rsp_route;
    logic [63:0] flt_tag, flt_va_form;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic        e_valid = 0, e_hit = 0, e_miss = 0, e_fault = 0, e_lookup = 0;
    logic [2:0]  e_route = 0;
    logic [63:0] e_pa = 0, e_tag = 0, e_form = 0;
    logic [29:0] e_vpn = 0;
    string       e_req = "R11";

    always #5 clk = ~clk;

    ifetch_xlate_front u_ifetch_xlate_front (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_phys(req_phys), .cur_mode(cur_mode), .ptbr(ptbr),
        .tlb_lookup(tlb_lookup), .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_route(rsp_route), .flt_tag(flt_tag), .flt_va_form(flt_va_form)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_rsp();
        chk(e_req, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
        chk(e_req, "rsp_hit",   64'(rsp_hit),   64'(e_hit));
        chk(e_req, "rsp_miss",  64'(rsp_miss),  64'(e_miss));
        chk(e_req, "rsp_fault", 64'(rsp_fault), 64'(e_fault));
        chk(e_req, "rsp_route", 64'(rsp_route), 64'(e_route));
        chk(e_req, "rsp_pa",    rsp_pa, e_pa);
        chk(e_req, "flt_tag",   flt_tag, e_tag);
        chk(e_req, "flt_va_form", flt_va_form, e_form);
    endtask

    // Behavioural reference: computes the response due one edge later.
    task automatic model(input logic v, input logic [63:0] va, input logic ph,
                         input logic [1:0] md, input logic th, input logic [30:0] tp);
        logic ok;
        e_valid = v; e_hit = 0; e_miss = 0; e_fault = 0; e_route = 0;
        e_pa = 0; e_lookup = 0; e_vpn = va[42:13];
        ok = (va[63:42] == 22'h3FFFFF) || (va[63:42] == 22'h0);
        if (v) begin
            if (va[0]) begin
                e_route = 0; e_hit = 1; e_pa = {20'h0, va[43:2], 2'b00};
            end else if (ph) begin
                e_route = 1; e_hit = 1; e_pa = va;
            end else if (!ok) begin
                e_route = 2; e_fault = 1;
            end else if (va[47:41] == 7'h7E) begin
                e_route = 3;
                if (md == 2'd0) begin e_hit = 1; e_pa = {23'h0, va[40:0]}; end
                else e_fault = 1;
            end else begin
                e_route = 4; e_lookup = 1;
                if (th) begin e_hit = 1; e_pa = {20'h0, tp, va[12:0]}; end
                else e_miss = 1;
            end
            if (e_fault) begin
                e_tag  = va;
                e_form = ptbr | {31'h0, va[42:13], 3'b000};
            end
        end
    endtask

    task automatic step(input logic v, input logic [63:0] va, input logic ph,
                        input logic [1:0] md, input logic th, input logic [30:0] tp,
                        input string req);
        @(negedge clk);
        compare_rsp();
        req_valid = v; req_va = va; req_phys = ph; cur_mode = md;
        tlb_hit = th; tlb_ppn = tp;
        model(v, va, ph, md, th, tp);
        e_req = req;
        #1;
        chk(req, "tlb_lookup", 64'(tlb_lookup), 64'(e_lookup));
        if (e_lookup) chk(req, "tlb_vpn", 64'(tlb_vpn), 64'(e_vpn));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // first compare of step checks the reset state (R11)
        step(1, 64'hFFFF_FFFF_8765_4321, 0, 3, 0, 0, "R1");
        step(1, 64'h8000_0000_0000_0007, 1, 3, 1, 31'h1, "R10");   // marker beats phys and range
        step(1, 64'h0000_0800_0000_1000, 1, 3, 0, 0, "R2");        // phys beats range check
        step(1, 64'hFFFF_FC00_1234_5678, 1, 1, 0, 0, "R10");       // phys beats window
        step(1, 64'h0000_0800_0000_2000, 0, 0, 1, 31'h5, "R3");    // bit43 set, bit42 clear
        step(1, 64'h8000_0000_0001_0000, 0, 0, 0, 0, "R3");
        step(0, 64'h0, 0, 0, 0, 0, "R6");                          // idle: capture holds
        step(1, 64'hFFFF_FC00_0000_2468, 0, 0, 1, 31'h7FFF_FFFF, "R4");
        step(1, 64'hFFFF_FDFF_FFFF_E000, 0, 0, 0, 0, "R4");
        step(1, 64'hFFFF_FC00_0000_2468, 0, 3, 0, 0, "R5");
        step(1, 64'hFFFF_FD00_ABCD_0000, 0, 1, 0, 0, "R5");
        step(1, 64'hFFFF_FC00_0000_4000, 0, 2, 0, 0, "R5");
        step(1, 64'h0000_0000_1234_5678, 0, 3, 1, 31'h2AAA_5555, "R7");
        step(1, 64'hFFFF_FE00_0000_3FFC, 0, 0, 1, 31'h0000_0123, "R7");
        step(1, 64'h0000_03FF_FFFF_FFFE, 0, 3, 0, 31'h1234, "R8");
        step(1, 64'hFFFF_FE00_0000_0000, 0, 0, 0, 0, "R8");
        step(0, 64'h0, 0, 0, 0, 0, "R9");
        step(0, 64'h0, 0, 0, 0, 0, "R9");
        ptbr = 64'hFFFF_0000_0000_0005;
        step(1, 64'h0000_1000_0000_8000, 0, 0, 0, 0, "R6");
        step(1, 64'h0000_0000_0000_A001, 0, 0, 0, 0, "R1");
        step(0, 64'h0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        compare_rsp();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule